// File: doc/BRIEF.md
# Parallel Memory Read Timing Controller

This block sits on the host side of an asynchronous byte-wide read-only memory with 512K locations. A system-side master offers a 19-bit address with a valid/ready handshake. The controller presents the address and pulls the chip enable low in the same clock edge. It pulls the output enable low later, once the data still has just enough output-enable access time left before the address access time expires. When the slowest of the access windows has elapsed, it captures the byte and returns it with a one-cycle acknowledge.

It then releases the output enable, then the chip enable one cycle later. It keeps the bus quiet for the output-float interval before it accepts another address, so that another device on the same data lines never meets a memory that is still driving. All wait counts are computed at elaboration from two parameters: the clock period in nanoseconds and the speed grade. Each nanosecond limit is rounded up to whole cycles.

Top module: `prom_reader`

## Requirements
- R1: After reset the chip enable and output enable are high, the acknowledge is low and the request ready is high.
- R2: When request valid and ready are both high at a clock edge, that edge loads the memory address from the request address and drives the chip enable low. Ready is low from then on until the access and its float gap are complete.
- R3: The output enable goes low exactly D = A - O cycles after the edge that lowered the chip enable, and stays low until the capture edge. A is the address access count and O is the output-enable access count (see R9).
- R4: While the chip enable is low, the memory address does not change.
- R5: The acknowledge is high for exactly one cycle, beginning A+1 cycles after the chip-enable edge. During that cycle the returned byte equals the memory data sampled at that edge. The returned byte holds its value at all other times.
- R6: The output enable is never low while the chip enable is high. The output enable rises at the acknowledge edge, and the chip enable rises one cycle after it.
- R7: Ready goes high again F cycles after the chip enable rises, where F is the float count (see R9).
- R8: A request held valid while ready is low has no effect: the address and enables keep their values and no extra acknowledge occurs.
- R9: With clock period P ns, A = ceil(tA/P), O = ceil(tO/P) and F = ceil(tF/P). Speed grades 0, 1, 2 and 3 give tA = 90, 120, 150, 200 ns; tO = 40, 50, 65, 75 ns; and tF = 30, 30, 30, 40 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Read request offered |
| reqAddr | input | 19 | Byte address of the request |
| reqReady | output | 1 | Controller can take a request |
| ackValid | output | 1 | One-cycle pulse: returned byte valid |
| ackData | output | 8 | Captured byte |
| romAddr | output | 19 | Address to the memory |
| romCeN | output | 1 | Active-low chip enable to the memory |
| romOeN | output | 1 | Active-low output enable to the memory |
| romData | input | 8 | Data from the memory |

## Verification
A miscounted wait shows up within one access. If the output enable falls a cycle early or late, the next cycle's enable check catches it. If capture happens even one cycle early, the byte returned is the inverted value the bench memory model drives until both access windows have elapsed. A wrong state after capture, or a short float count, shows as ready reappearing too soon or as the chip enable rising out of order, within F+2 cycles of the acknowledge. A request accepted while busy shows at once as an address change under a low chip enable.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

  typedef struct packed {
    logic loadAddr;
    logic capture;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_RELEASE,
    ST_FLOAT
  } rdState_t;

  function automatic int addrAccessNs(input int grade);
    case (grade)
      0:       return 90;
      1:       return 120;
      2:       return 150;
      default: return 200;
    endcase
  endfunction

  function automatic int oeAccessNs(input int grade);
    case (grade)
      0:       return 40;
      1:       return 50;
      2:       return 65;
      default: return 75;
    endcase
  endfunction

  function automatic int floatNs(input int grade);
    return (grade >= 3) ? 40 : 30;
  endfunction

  function automatic int nsToCycles(input int ns, input int periodNs);
    return (ns + periodNs - 1) / periodNs;
  endfunction

endpackage

// File: rtl/prom_rd_ctrl.sv
module prom_rd_ctrl
  import prom_rd_pkg::*;
#(
  parameter int ACC_CYC = 9,
  parameter int OE_CYC  = 4,
  parameter int DF_CYC  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       ackValid,
  output logic       romCeN,
  output logic       romOeN,
  output dpStrobe_t  strobe
);

  localparam int OE_DLY    = ACC_CYC - OE_CYC;
  localparam int CNT_MAX   = (ACC_CYC > DF_CYC) ? ACC_CYC : DF_CYC;
  localparam int CNT_W     = $clog2(CNT_MAX + 1) + 1;
  localparam int OE_FIRE_I = (OE_DLY > 0) ? OE_DLY - 1 : 0;
  localparam int DF_LAST_I = (DF_CYC > 0) ? DF_CYC - 1 : 0;
  localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACC_CYC);
  localparam logic [CNT_W-1:0] OE_FIRE  = CNT_W'(OE_FIRE_I);
  localparam logic [CNT_W-1:0] DF_LAST  = CNT_W'(DF_LAST_I);

  rdState_t         state;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             captureNow;

  assign reqReady   = (state == ST_IDLE);
  assign accept     = reqReady && reqValid;
  assign captureNow = (state == ST_ACCESS) && (cnt == ACC_LAST);

  always_comb begin
    strobe          = '0;
    strobe.loadAddr = accept;
    strobe.capture  = captureNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      romCeN   <= 1'b1;
      romOeN   <= 1'b1;
      ackValid <= 1'b0;
    end else begin
      ackValid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            romCeN <= 1'b0;
            if (OE_DLY == 0) romOeN <= 1'b0;
            cnt    <= '0;
            state  <= ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          cnt <= cnt + 1'b1;
          if ((OE_DLY > 0) && (cnt == OE_FIRE)) romOeN <= 1'b0;
          if (captureNow) begin
            ackValid <= 1'b1;
            romOeN   <= 1'b1;
            state    <= ST_RELEASE;
          end
        end
        ST_RELEASE: begin
          romCeN <= 1'b1;
          cnt    <= '0;
          state  <= ST_FLOAT;
        end
        ST_FLOAT: begin
          cnt <= cnt + 1'b1;
          if (cnt == DF_LAST) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> !ackValid);

  assert_oe_inside_ce_R6: assert property (@(posedge clk) disable iff (!rstN)
    !romOeN |-> !romCeN);

  assert_ce_after_oe_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!romCeN && $rose(romOeN)) |=> $rose(romCeN));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!reqReady && !romCeN));

  assert_ack_on_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (romOeN && !romCeN));

endmodule

// File: rtl/prom_rd_dp.sv
module prom_rd_dp
  import prom_rd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              romCeN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] ackData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romAddr <= '0;
      ackData <= '0;
    end else begin
      if (strobe.loadAddr) romAddr <= reqAddr;
      if (strobe.capture)  ackData <= romData;
    end
  end

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!romCeN && $past(!romCeN)) |-> $stable(romAddr));

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.capture) |-> $stable(ackData));

endmodule

// File: rtl/prom_reader.sv
module prom_reader
  import prom_rd_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 12,
  parameter int SPEED_GRADE   = 0,
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              ackValid,
  output logic [DATA_W-1:0] ackData,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romCeN,
  output logic              romOeN,
  input  logic [DATA_W-1:0] romData
);

  localparam int ACC_CYC = nsToCycles(addrAccessNs(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int OE_RAW  = nsToCycles(oeAccessNs(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int OE_CYC  = (OE_RAW > ACC_CYC) ? ACC_CYC : OE_RAW;
  localparam int DF_RAW  = nsToCycles(floatNs(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int DF_CYC  = (DF_RAW < 1) ? 1 : DF_RAW;

  dpStrobe_t strobe;

  prom_rd_ctrl #(
    .ACC_CYC(ACC_CYC),
    .OE_CYC (OE_CYC),
    .DF_CYC (DF_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .ackValid(ackValid),
    .romCeN  (romCeN),
    .romOeN  (romOeN),
    .strobe  (strobe)
  );

  prom_rd_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .romCeN (romCeN),
    .reqAddr(reqAddr),
    .romData(romData),
    .romAddr(romAddr),
    .ackData(ackData)
  );

endmodule

// File: tb/prom_reader_bench.sv
module prom_reader_bench;

  localparam int CLK_NS = 12;
  localparam int GRADE  = 2;

  function automatic int ceilDiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  localparam int T_ACC = (GRADE == 0) ? 90 : (GRADE == 1) ? 120 : (GRADE == 2) ? 150 : 200;
  localparam int T_OE  = (GRADE == 0) ? 40 : (GRADE == 1) ? 50 : (GRADE == 2) ? 65 : 75;
  localparam int T_DF  = (GRADE == 3) ? 40 : 30;
  localparam int A = ceilDiv(T_ACC, CLK_NS);
  localparam int O = ceilDiv(T_OE, CLK_NS);
  localparam int F = ceilDiv(T_DF, CLK_NS);
  localparam int D = A - O;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [18:0] reqAddr = '0;
  logic        reqReady, ackValid, romCeN, romOeN;
  logic [7:0]  ackData, romData;
  logic [18:0] romAddr;

  int errors = 0;
  int checks = 0;
  int ceAge = 0;
  int oeAge = 0;
  bit done = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  prom_reader #(.CLK_PERIOD_NS(CLK_NS), .SPEED_GRADE(GRADE)) u_prom_reader (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .ackValid(ackValid), .ackData(ackData),
    .romAddr(romAddr), .romCeN(romCeN), .romOeN(romOeN), .romData(romData)
  );

  function automatic logic [7:0] romByte(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b10110, a[18:16]};
  endfunction

  // memory model: valid byte only once both access windows have elapsed
  always @(posedge clk) begin
    ceAge <= romCeN ? 0 : ceAge + 1;
    oeAge <= romOeN ? 0 : oeAge + 1;
  end
  assign romData = (!romCeN && !romOeN && ceAge >= A && oeAge >= O)
                   ? romByte(romAddr) : ~romByte(romAddr);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doRead(input logic [18:0] a, input bit holdValid);
    int guard = 0;
    while (!reqReady && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    reqValid = 1'b1;
    reqAddr  = a;
    @(negedge clk);
    // k = 0: just after the accept edge
    check(romCeN == 1'b0, "R2 ce low", romCeN, 0);
    check(romAddr == a, "R2 addr", romAddr, a);
    check(reqReady == 1'b0, "R2 ready low", reqReady, 0);
    check(romOeN == (D > 0), "R3 oe at k0", romOeN, (D > 0));
    if (holdValid) reqAddr = ~a;
    else reqValid = 1'b0;
    for (int k = 1; k <= A; k++) begin
      @(negedge clk);
      check(romOeN == (k < D), "R3 oe timing", romOeN, (k < D));
      check(romCeN == 1'b0 && romAddr == a, "R4 addr/ce hold", romAddr, a);
      check(ackValid == 1'b0, "R5 no early ack", ackValid, 0);
      if (holdValid) check(reqReady == 1'b0, "R8 busy ignored", reqReady, 0);
    end
    @(negedge clk); // k = A+1
    check(ackValid == 1'b1, "R5 ack", ackValid, 1);
    check(ackData == romByte(a), "R5 data", ackData, romByte(a));
    check(romOeN == 1'b1 && romCeN == 1'b0, "R6 oe first", {romOeN, romCeN}, 2'b10);
    @(negedge clk); // k = A+2, chip enable has risen
    check(ackValid == 1'b0, "R5 single pulse", ackValid, 0);
    check(romCeN == 1'b1, "R6 ce second", romCeN, 1);
    check(romAddr == a, "R8 addr kept", romAddr, a);
    for (int j = 1; j <= F; j++) begin
      if (j == F && holdValid) reqValid = 1'b0;
      @(negedge clk);
      check(reqReady == (j >= F), "R7 float gap", reqReady, (j >= F));
      check(ackValid == 1'b0, "R8 no extra ack", ackValid, 0);
    end
    check(ackData == romByte(a), "R5 data held", ackData, romByte(a));
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24601));
    check(A == 13 && O == 6 && F == 3, "R9 grade table", A, 13);
    repeat (3) @(negedge clk);
    check(romCeN && romOeN && !ackValid && reqReady, "R1 reset state",
          {romCeN, romOeN, ackValid, reqReady}, 4'b1101);
    rstN = 1'b1;
    @(negedge clk);
    check(romCeN && romOeN && !ackValid && reqReady, "R1 after release",
          {romCeN, romOeN, ackValid, reqReady}, 4'b1101);
    doRead(19'h00000, 1'b0);
    doRead(19'h7FFFF, 1'b0);
    doRead(19'h2A5A5, 1'b1);   // R8: request held during busy
    doRead(19'h15A5A, 1'b0);   // back-to-back at first ready
    for (int n = 0; n < 40; n++) begin
      int gap = $urandom_range(0, 3);
      repeat (gap) @(negedge clk);
      doRead(19'($urandom), 1'($urandom_range(0, 1)));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule